// File: doc/BRIEF.md
# Calendar Time Counter with BCD or Binary Fields

This block holds a full wall-clock date in eight byte-wide fields: seconds, minutes, hours, day of week, day of month, month, year within the century, and century. Each accepted one-second tick adds one to the seconds field. Carries then ripple through the other fields in the same clock cycle, so every field always reads as a consistent date.

Two global inputs set how the bytes are interpreted. One selects packed BCD or plain binary for every field together. The other selects 24-hour or 12-hour hours, where the hours byte also carries a PM flag. If either mode changes, software is expected to rewrite all fields. A halt input makes the block ignore ticks, so software can read or load a consistent set of fields. Each field has its own write enable and can be loaded in parallel from a shared data bus.

Top module: `cal_counter`

## Requirements
- R1: After reset, seconds, minutes, hours, year and century read 0x00, and day of week, day of month and month read 0x01.
- R2: A tick accepted while halt_i is 0 and no write enable is set adds one to the seconds field on that clock edge. Seconds wrap from 59 to 0 and step minutes. Minutes wrap from 59 to 0 and step hours.
- R3: With bin_mode_i at 0, every field is packed BCD, with tens in bits 7:4 and units in bits 3:0 (so 9 steps to 0x10). With bin_mode_i at 1, every field is a plain binary count (9 steps to 0x0A). Both modes use the same ranges.
- R4: With hr24_i at 1, hours run 0 to 23. The step from 23 to 0 advances the date.
- R5: With hr24_i at 0, bits 6:0 of the hours byte hold 1 to 12 and bit 7 is the PM flag (1 = PM). 11 AM steps to 12 PM. 12 steps to 1 with the flag kept. 11 PM steps to 12 AM and advances the date.
- R6: Day of week runs 1 to 7, with 1 standing for Sunday. It steps on every date advance and wraps from 7 to 1.
- R7: Day of month wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year within the century is divisible by 4, and 28 otherwise. All other months have 31 days.
- R8: Month wraps from 12 to 1 and steps the year. Year wraps from 99 to 0 and steps the century. Century wraps from 99 to 0.
- R9: While halt_i is 1, ticks are ignored and every field holds its value.
- R10: wr_en_i[k] loads byte k of wr_data_i (bits 8k+7:8k) into field k on the next edge, halted or not. The field order k = 0..7 is seconds, minutes, hours, day of week, day of month, month, year, century.
- R11: In a cycle where any write enable is set, a tick is discarded and no field that is not being written changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance strobe, one cycle wide |
| halt_i | input | 1 | Freeze: ticks are ignored while high |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = packed BCD fields |
| hr24_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM flag in bit 7 |
| wr_en_i | input | 8 | Per-field load enables, bit k for field k |
| wr_data_i | input | 64 | Load data, byte k for field k |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours (PM flag in bit 7 in 12-hour mode) |
| dow_o | output | 8 | Day of week |
| dom_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| cent_o | output | 8 | Century |

## Verification
A one-second tick and a field load can arrive in the same cycle. The block must then drop the tick entirely, so a partial load never mixes with a carry. The bench provokes this with single-field loads issued together with a tick, both in directed cases and at random. It then checks that the written field holds the loaded byte and that every other field, seconds included, still shows its value from before. The same comparison against the bench's own date model covers loads issued while halted, where the written field must change and the rest must stay frozen.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FLD_W = 8;
  localparam int N_FLD = 8;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  typedef logic [FLD_W-1:0] fld_t;

  // lower value, upper value (decoded) and reset byte per field
  localparam fld_t LO_TAB  [N_FLD] = '{8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0};
  localparam fld_t HI_TAB  [N_FLD] = '{8'd59, 8'd59, 8'd23, 8'd7, 8'd31, 8'd12, 8'd99, 8'd99};
  localparam fld_t RST_TAB [N_FLD] = '{8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0};

  localparam fld_t HR12_TOP = 8'd12;
  localparam fld_t HR12_PRE = 8'd11;
  localparam fld_t FEB_NUM  = 8'd2;

  function automatic fld_t fdec(fld_t v, logic bin);
    fld_t t;
    t = {4'b0, v[7:4]} * 8'd10 + {4'b0, v[3:0]};
    return bin ? v : t;
  endfunction

  function automatic fld_t fenc(fld_t n, logic bin);
    fld_t t;
    fld_t r;
    t = n / 8'd10;
    r = n % 8'd10;
    return bin ? n : {t[3:0], r[3:0]};
  endfunction
endpackage

// File: rtl/cal_field_inc.sv
module cal_field_inc
  import cal_pkg::*;
(
  input  fld_t val_i,
  input  fld_t lo_i,
  input  fld_t hi_i,
  input  logic bin_i,
  output fld_t nxt_o,
  output logic wrap_o
);
  fld_t d;

  always_comb begin
    d      = fdec(val_i, bin_i);
    // at or beyond the upper value: restart at the lower value
    wrap_o = (d >= hi_i);
    nxt_o  = wrap_o ? fenc(lo_i, bin_i) : fenc(d + 8'd1, bin_i);
  end
endmodule

// File: rtl/cal_hour_inc.sv
module cal_hour_inc
  import cal_pkg::*;
(
  input  fld_t val_i,
  input  logic bin_i,
  input  logic hr24_i,
  output fld_t nxt_o,
  output logic day_o
);
  fld_t h24, h12, e_one, e_top, e_inc12;
  logic pm;

  always_comb begin
    pm      = val_i[7];
    h24     = fdec(val_i, bin_i);
    h12     = fdec({1'b0, val_i[6:0]}, bin_i);
    e_one   = fenc(8'd1, bin_i);
    e_top   = fenc(HR12_TOP, bin_i);
    e_inc12 = fenc(h12 + 8'd1, bin_i);
    nxt_o   = '0;
    day_o   = 1'b0;
    if (hr24_i) begin
      if (h24 >= HI_TAB[F_HOUR]) begin
        nxt_o = fenc(8'd0, bin_i);
        day_o = 1'b1;
      end else begin
        nxt_o = fenc(h24 + 8'd1, bin_i);
      end
    end else if (h12 >= HR12_TOP) begin
      nxt_o = {pm, e_one[6:0]};
    end else if (h12 == HR12_PRE) begin
      // noon and midnight flip the flag; only midnight moves the date
      nxt_o = {~pm, e_top[6:0]};
      day_o = pm;
    end else begin
      nxt_o = {pm, e_inc12[6:0]};
    end
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  fld_t mon_i,
  input  fld_t year_i,
  input  logic bin_i,
  output fld_t len_o
);
  fld_t m, y;

  always_comb begin
    m = fdec(mon_i, bin_i);
    y = fdec(year_i, bin_i);
    unique case (m)
      FEB_NUM:                    len_o = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:    len_o = 8'd30;
      default:                    len_o = HI_TAB[F_DOM];
    endcase
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   halt_i,
  input  logic                   bin_mode_i,
  input  logic                   hr24_i,
  input  logic [N_FLD-1:0]       wr_en_i,
  input  logic [N_FLD*FLD_W-1:0] wr_data_i,
  output logic [FLD_W-1:0]       sec_o,
  output logic [FLD_W-1:0]       min_o,
  output logic [FLD_W-1:0]       hour_o,
  output logic [FLD_W-1:0]       dow_o,
  output logic [FLD_W-1:0]       dom_o,
  output logic [FLD_W-1:0]       mon_o,
  output logic [FLD_W-1:0]       year_o,
  output logic [FLD_W-1:0]       cent_o
);
  fld_t             q    [N_FLD];
  fld_t             nxt  [N_FLD];
  fld_t             hi   [N_FLD];
  logic [N_FLD-1:0] wrap;
  logic [N_FLD-1:0] en;
  fld_t             mlen;
  logic             step_ok;

  // a load in the same cycle discards the tick
  assign step_ok = tick_i & ~halt_i & ~(|wr_en_i);

  cal_month_len i_mlen (
    .mon_i  (q[F_MON]),
    .year_i (q[F_YEAR]),
    .bin_i  (bin_mode_i),
    .len_o  (mlen)
  );

  always_comb begin
    for (int k = 0; k < N_FLD; k++) hi[k] = HI_TAB[k];
    hi[F_DOM] = mlen;
  end

  always_comb begin
    en[F_SEC]  = 1'b1;
    en[F_MIN]  = wrap[F_SEC];
    en[F_HOUR] = en[F_MIN] & wrap[F_MIN];
    en[F_DOW]  = en[F_HOUR] & wrap[F_HOUR];
    en[F_DOM]  = en[F_DOW];
    en[F_MON]  = en[F_DOM] & wrap[F_DOM];
    en[F_YEAR] = en[F_MON] & wrap[F_MON];
    en[F_CENT] = en[F_YEAR] & wrap[F_YEAR];
  end

  for (genvar k = 0; k < N_FLD; k++) begin : g_fld
    if (k == F_HOUR) begin : g_hour
      cal_hour_inc i_inc (
        .val_i  (q[k]),
        .bin_i  (bin_mode_i),
        .hr24_i (hr24_i),
        .nxt_o  (nxt[k]),
        .day_o  (wrap[k])
      );
    end else begin : g_plain
      cal_field_inc i_inc (
        .val_i  (q[k]),
        .lo_i   (LO_TAB[k]),
        .hi_i   (hi[k]),
        .bin_i  (bin_mode_i),
        .nxt_o  (nxt[k]),
        .wrap_o (wrap[k])
      );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              q[k] <= RST_TAB[k];
      else if (wr_en_i[k])      q[k] <= wr_data_i[k*FLD_W +: FLD_W];
      else if (step_ok && en[k]) q[k] <= nxt[k];
    end

    AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[k] |=> q[k] == $past(wr_data_i[k*FLD_W +: FLD_W])); // R10
    AST_WR_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|wr_en_i && !wr_en_i[k]) |=> $stable(q[k])); // R11
  end

  assign sec_o  = q[F_SEC];
  assign min_o  = q[F_MIN];
  assign hour_o = q[F_HOUR];
  assign dow_o  = q[F_DOW];
  assign dom_o  = q[F_DOM];
  assign mon_o  = q[F_MON];
  assign year_o = q[F_YEAR];
  assign cent_o = q[F_CENT];

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !(|wr_en_i)) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(dow_o) && $stable(dom_o) && $stable(mon_o) && $stable(year_o) && $stable(cent_o))); // R9
  AST_MIN_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_ok && fdec(sec_o, bin_mode_i) < HI_TAB[F_SEC]) |=> $stable(min_o)); // R2
  AST_DOW_WITH_DOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_ok |=> ((dom_o != $past(dom_o)) == (dow_o != $past(dow_o)))); // R6
  AST_CENT_ROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_ok && en[F_CENT] && wrap[F_CENT]) |=> (year_o == 8'h00 && cent_o == 8'h00)); // R8
endmodule

// File: tb/test_cal_counter.sv
module test_cal_counter;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, halt = 1'b0, bin = 1'b0, h24 = 1'b1;
  logic [7:0]  wr_en = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  sec, mn, hr, dw, dm, mo, yr, ce;

  int n_chk = 0, n_bad = 0;
  // bench date model, decoded values
  int m_sec, m_min, m_hr, m_pm, m_dow, m_dom, m_mon, m_yr, m_cen;

  always #(CLK_P/2) clk = ~clk;

  cal_counter i_cal_counter (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .halt_i(halt),
    .bin_mode_i(bin), .hr24_i(h24), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(mn), .hour_o(hr), .dow_o(dw), .dom_o(dm),
    .mon_o(mo), .year_o(yr), .cent_o(ce)
  );

  function automatic logic [7:0] enc(int v);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(int mo_v, int yr_v);
    if (mo_v == 2) return (yr_v % 4 == 0) ? 29 : 28;
    if (mo_v == 4 || mo_v == 6 || mo_v == 9 || mo_v == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hbyte();
    return h24 ? enc(m_hr) : (enc(m_hr) | (m_pm != 0 ? 8'h80 : 8'h00));
  endfunction

  function automatic logic [63:0] exp_vec();
    return {enc(m_cen), enc(m_yr), enc(m_mon), enc(m_dom), enc(m_dow), hbyte(), enc(m_min), enc(m_sec)};
  endfunction

  task automatic model_tick();
    bit day;
    day = 0;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0;
    if (h24) begin
      m_hr++;
      if (m_hr == 24) begin m_hr = 0; day = 1; end
    end else if (m_hr == 12) m_hr = 1;
    else if (m_hr == 11) begin m_hr = 12; day = (m_pm != 0); m_pm = (m_pm != 0) ? 0 : 1; end
    else m_hr++;
    if (!day) return;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_dom < mlen(m_mon, m_yr)) begin m_dom++; return; end
    m_dom = 1;
    if (m_mon < 12) begin m_mon++; return; end
    m_mon = 1;
    if (m_yr < 99) begin m_yr++; return; end
    m_yr = 0;
    m_cen = (m_cen == 99) ? 0 : m_cen + 1;
  endtask

  task automatic chk(string tag);
    logic [63:0] act, ex;
    act = {ce, yr, mo, dm, dw, hr, mn, sec};
    ex  = exp_vec();
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, ex);
    end
  endtask

  task automatic cyc(bit tk, bit hl, string tag);
    tick = tk; halt = hl; wr_en = '0;
    @(posedge clk); #1;
    if (tk && !hl) model_tick();
    tick = 1'b0; halt = 1'b0;
    chk(tag);
  endtask

  task automatic load_all(bit b, bit t24, int s, int mi, int h, int pm, int dow, int dom,
                          int mon, int y, int c, bit tk, string tag);
    bin = b; h24 = t24;
    m_sec = s; m_min = mi; m_hr = h; m_pm = t24 ? 0 : pm;
    m_dow = dow; m_dom = dom; m_mon = mon; m_yr = y; m_cen = c;
    wr_data = exp_vec(); wr_en = 8'hFF; tick = tk; halt = 1'b0;
    @(posedge clk); #1;
    wr_en = '0; tick = 1'b0;
    chk(tag);
  endtask

  // field 0 = seconds, 1 = minutes, 6 = year
  task automatic wr_one(int k, int v, bit tk, bit hl, string tag);
    if (k == 0) m_sec = v; else if (k == 1) m_min = v; else m_yr = v;
    wr_data = '0;
    wr_data[k*8 +: 8] = enc(v);
    wr_en = 8'(1 << k); tick = tk; halt = hl;
    @(posedge clk); #1;
    wr_en = '0; tick = 1'b0; halt = 1'b0;
    chk(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd8221);
    m_sec = 0; m_min = 0; m_hr = 0; m_pm = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_yr = 0; m_cen = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset");
    cyc(1, 0, "R2 first tick");

    // R3: units carry in both encodings
    load_all(0, 1, 9, 0, 0, 0, 1, 1, 1, 0, 20, 0, "R3 load bcd");
    cyc(1, 0, "R3 bcd 09->10");
    load_all(1, 1, 9, 0, 0, 0, 1, 1, 1, 0, 20, 0, "R3 load bin");
    cyc(1, 0, "R3 bin 09->0A");
    // R2: seconds and minutes carry
    load_all(0, 1, 59, 59, 5, 0, 2, 10, 3, 5, 20, 0, "R2 load");
    cyc(1, 0, "R2 minute and hour carry");

    // R4 R6 R7 R8: end of year, bcd 24h
    load_all(0, 1, 59, 59, 23, 0, 7, 31, 12, 99, 20, 0, "R8 load");
    cyc(1, 0, "R8 year wrap, R6 dow 7->1, R4 23->0");
    load_all(1, 1, 59, 59, 23, 0, 3, 31, 12, 99, 99, 0, "R8 load cent");
    cyc(1, 0, "R8 century 99->0");

    // R7: month lengths
    load_all(0, 1, 59, 59, 23, 0, 1, 28, 2, 23, 20, 0, "R7 load");
    cyc(1, 0, "R7 feb 28 common year");
    load_all(0, 1, 59, 59, 23, 0, 1, 28, 2, 24, 20, 0, "R7 load");
    cyc(1, 0, "R7 feb 28 leap year");
    m_sec = 59; m_min = 59; m_hr = 23;
    load_all(1, 1, 59, 59, 23, 0, 2, 29, 2, 24, 20, 0, "R7 load");
    cyc(1, 0, "R7 feb 29 leap year");
    load_all(1, 1, 59, 59, 23, 0, 2, 30, 4, 24, 20, 0, "R7 load");
    cyc(1, 0, "R7 april 30");

    // R5: 12-hour transitions, both encodings
    for (int b = 0; b < 2; b++) begin
      load_all(b[0], 0, 59, 59, 11, 0, 4, 15, 6, 30, 20, 0, "R5 load");
      cyc(1, 0, "R5 11AM->12PM");
      load_all(b[0], 0, 59, 59, 12, 1, 4, 15, 6, 30, 20, 0, "R5 load");
      cyc(1, 0, "R5 12PM->1PM");
      load_all(b[0], 0, 59, 59, 11, 1, 4, 31, 1, 30, 20, 0, "R5 load");
      cyc(1, 0, "R5 11PM->12AM next day");
    end

    // R9 halt, R10 load while halted
    load_all(0, 1, 30, 10, 10, 0, 3, 3, 3, 3, 20, 0, "R10 load");
    for (int i = 0; i < 5; i++) cyc(1, 1, "R9 halted tick");
    wr_one(0, 45, 1, 1, "R10 write under halt");
    cyc(1, 0, "R9 resume");
    // R11: write with tick, tick discarded
    wr_one(1, 7, 1, 0, "R11 write min with tick");
    wr_one(6, 42, 1, 0, "R11 write year with tick");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 3) begin
        int mo_v, yr_v, t24;
        mo_v = 1 + $urandom % 12;
        yr_v = ($urandom % 4 == 0) ? 99 : $urandom % 100;
        t24 = $urandom % 2;
        load_all(1'($urandom % 2), 1'(t24), 55 + $urandom % 5, 58 + $urandom % 2,
                 t24 != 0 ? 22 + $urandom % 2 : 10 + $urandom % 3, $urandom % 2,
                 1 + $urandom % 7, mlen(mo_v, yr_v) - $urandom % 2, mo_v, yr_v,
                 97 + $urandom % 3, 1'($urandom % 2), "R10 random load");
      end else if (r < 6) begin
        int k;
        k = ($urandom % 3 == 2) ? 6 : $urandom % 2;
        wr_one(k, (k == 6) ? $urandom % 100 : $urandom % 60, 1'($urandom % 2),
               1'($urandom % 2), "R11 random write");
      end else begin
        cyc(1'($urandom % 2), ($urandom % 8) == 0, "R3 random step");
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule